// File: doc/BRIEF.md
# Multi-User Interprocessor Mailbox

This block lets several processors pass 32-bit words to one another through a shared register map. It contains a number of independent message queues. Any bus master may push a word into any queue by writing its message address, and may pop the oldest word by reading that same address. Per-queue registers report whether the queue is full and how many words are still unread.

Each processor ("user") has its own interrupt view. Every queue raises two events: a new-message event when a push is accepted, and a not-full event when a pop frees the last slot. Both are recorded in the status register of every user. A user picks the events it wants to hear about through separate enable-set and enable-clear addresses. It acknowledges an event by writing 1 to the status bit. The user's interrupt line is high while any enabled status bit is set.

The bus is synchronous and has a write port and a read port, each with its own address, so one write and one read can occur in the same cycle. Read data is registered and appears in the cycle after the read strobe.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset every queue is empty, every status and enable bit is 0, and every interrupt line is low.
- R2: `rd_data` holds the addressed register value in the cycle after a cycle with `rd_en` high, and 0 after any cycle without `rd_en`. The read-only revision register at offset 0x000 returns the `REVISION` parameter, and writes to it are ignored.
- R3: A write to offset 0x040 + 4*m pushes `wr_data` into queue m, which holds `DEPTH` words. A push to a full queue is discarded, and the queue contents and level do not change.
- R4: A read of offset 0x040 + 4*m pops and returns the oldest word of queue m, in first-in first-out order. A read of an empty queue returns 0 and leaves the queue unchanged. A read and a write to the same queue in one cycle are both honoured against the level held before that cycle.
- R5: Offset 0x080 + 4*m reads 1 when queue m is full and 0 otherwise. Offset 0x0C0 + 4*m reads the number of unread words in queue m.
- R6: In each user's status and enable registers, bit 2m is the new-message event of queue m and bit 2m+1 is its not-full event. An accepted push to queue m sets bit 2m in every user's status. A pop from a full queue m sets bit 2m+1 in every user's status.
- R7: The status register of user u is at offset 0x104 + 0x10*u and reads back its current value. Writing 1 to a bit clears it, and writing 0 leaves it unchanged. If an event and a clear hit the same bit in one cycle, the bit ends set.
- R8: For user u, writing 1s to offset 0x108 + 0x10*u sets those enable bits, and writing 1s to offset 0x10C + 0x10*u clears them. Zero bits leave the enables unchanged. Reading either offset returns the enable mask.
- R9: `irq_o[u]` is high exactly while the status of user u ANDed with its enable mask is nonzero.
- R10: Reads of unmapped offsets return 0, and writes to unmapped offsets, to the full-flag registers and to the level registers change nothing.
- R11: A status clear or enable change made through one user's addresses does not alter any other user's status, enables or interrupt line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Byte offset of the write |
| wr_data | input | DATA_W | Write data |
| rd_en | input | 1 | Read strobe; a read of a message offset pops |
| rd_addr | input | ADDR_W | Byte offset of the read |
| rd_data | output | DATA_W | Registered read data, valid the cycle after `rd_en` |
| irq_o | output | NUM_USERS | One interrupt line per user |

## Verification
Corrupted queue state, such as a wrong level or a pointer that has slipped, shows on the next pop or level read as a wrong word or count. Through the new-message and not-full bits it also shows one cycle later in every user's status and interrupt line. A wrong status or enable bit changes `irq_o` in the cycle after the offending access, before any read. The bench therefore compares every interrupt line after every access, and it compares read data on the cycle after each read against a model of the queues and event registers.

// File: rtl/ipc_mbox_pkg.sv
package ipc_mbox_pkg;

   // Base offsets of the register groups (byte addresses)
   localparam logic [11:0] OFS_REVISION = 12'h000;
   localparam logic [11:0] OFS_MESSAGE  = 12'h040;
   localparam logic [11:0] OFS_FULLFLAG = 12'h080;
   localparam logic [11:0] OFS_LEVEL    = 12'h0C0;
   localparam logic [11:0] OFS_USER     = 12'h104;

   localparam int QUEUE_STRIDE = 4;
   localparam int USER_STRIDE  = 16;

   // Register slots inside one user's window
   typedef enum int {
      USR_STATUS = 0,
      USR_EN_SET = 1,
      USR_EN_CLR = 2
   } user_slot_e;

   function automatic logic [11:0] queue_reg(logic [11:0] base, int m);
      return base + 12'(QUEUE_STRIDE * m);
   endfunction

   function automatic logic [11:0] user_reg(int u, user_slot_e slot);
      return OFS_USER + 12'(USER_STRIDE * u + 4 * int'(slot));
   endfunction

endpackage

// File: rtl/ipc_mbox_fifo.sv
module ipc_mbox_fifo #(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 4,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int LVL_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push_req,
   input  logic [DATA_W-1:0] push_data,
   input  logic              pop_req,
   output logic [DATA_W-1:0] head_data,
   output logic [LVL_W-1:0]  level,
   output logic              full,
   output logic              push_ok,
   output logic              nf_event
);

   logic [DATA_W-1:0] store [DEPTH];
   logic [PTR_W-1:0]  wptr_q, rptr_q;
   logic [LVL_W-1:0]  cnt_q;
   logic              pop_ok;

   assign full      = (cnt_q == LVL_W'(DEPTH));
   assign push_ok   = push_req && !full;
   assign pop_ok    = pop_req && (cnt_q != '0);
   assign nf_event  = pop_ok && full;
   assign level     = cnt_q;
   assign head_data = (cnt_q == '0) ? '0 : store[rptr_q];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wptr_q <= '0;
         rptr_q <= '0;
         cnt_q  <= '0;
      end else begin
         if (push_ok) wptr_q <= wptr_q + 1'b1;
         if (pop_ok)  rptr_q <= rptr_q + 1'b1;
         case ({push_ok, pop_ok})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (push_ok) store[wptr_q] <= push_data;
   end

endmodule

// File: rtl/ipc_mbox_user_irq.sv
module ipc_mbox_user_irq #(
   parameter int EV_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [EV_W-1:0] events,
   input  logic            ack_we,
   input  logic            set_we,
   input  logic            clr_we,
   input  logic [EV_W-1:0] wdata,
   output logic [EV_W-1:0] status,
   output logic [EV_W-1:0] enable,
   output logic            irq
);

   logic [EV_W-1:0] ack_mask;

   assign ack_mask = ack_we ? wdata : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         status <= '0;
         enable <= '0;
      end else begin
         // a fresh event outranks a simultaneous acknowledge
         status <= (status & ~ack_mask) | events;
         if (set_we)      enable <= enable | wdata;
         else if (clr_we) enable <= enable & ~wdata;
      end
   end

   assign irq = |(status & enable);

endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox #(
   parameter int          NUM_FIFOS = 4,
   parameter int          NUM_USERS = 4,
   parameter int          DEPTH     = 4,
   parameter int          DATA_W    = 32,
   parameter int          ADDR_W    = 12,
   parameter logic [31:0] REVISION  = 32'h0001_0200
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [ADDR_W-1:0]    wr_addr,
   input  logic [DATA_W-1:0]    wr_data,
   input  logic                 rd_en,
   input  logic [ADDR_W-1:0]    rd_addr,
   output logic [DATA_W-1:0]    rd_data,
   output logic [NUM_USERS-1:0] irq_o
);
   import ipc_mbox_pkg::*;

   localparam int EV_W  = 2 * NUM_FIFOS;
   localparam int LVL_W = $clog2(DEPTH + 1);
   localparam int TOP_OFS = 16'h104 + 16 * NUM_USERS;

   // elaboration-time parameter checks
   if (NUM_FIFOS < 1 || NUM_FIFOS > 16) begin : g_bad_fifos
      $error("NUM_FIFOS must lie in 1..16");
   end
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two, at least 2");
   end
   if (EV_W > DATA_W || DATA_W < 32) begin : g_bad_width
      $error("DATA_W must be at least 32 and hold all event bits");
   end
   if (ADDR_W < 12 || TOP_OFS > (1 << ADDR_W)) begin : g_bad_addr
      $error("ADDR_W too small for the user windows");
   end

   logic [DATA_W-1:0]                fifo_head [NUM_FIFOS];
   logic [NUM_FIFOS-1:0][LVL_W-1:0]  fifo_lvl;
   logic [NUM_FIFOS-1:0]             fifo_full;
   logic [NUM_FIFOS-1:0]             fifo_push_ok;
   logic [NUM_FIFOS-1:0]             fifo_nf_ev;
   logic [EV_W-1:0]                  events;
   logic [NUM_USERS-1:0][EV_W-1:0]   usr_stat;
   logic [NUM_USERS-1:0][EV_W-1:0]   usr_en;
   logic [DATA_W-1:0]                rd_val;

   // ---------------- message queues ----------------
   for (genvar m = 0; m < NUM_FIFOS; m++) begin : g_fifo
      logic push_hit, pop_hit;
      assign push_hit = wr_en && (wr_addr == ADDR_W'(queue_reg(OFS_MESSAGE, m)));
      assign pop_hit  = rd_en && (rd_addr == ADDR_W'(queue_reg(OFS_MESSAGE, m)));

      ipc_mbox_fifo #(
         .DATA_W (DATA_W),
         .DEPTH  (DEPTH)
      ) u_fifo (
         .clk       (clk),
         .rst_n     (rst_n),
         .push_req  (push_hit),
         .push_data (wr_data),
         .pop_req   (pop_hit),
         .head_data (fifo_head[m]),
         .level     (fifo_lvl[m]),
         .full      (fifo_full[m]),
         .push_ok   (fifo_push_ok[m]),
         .nf_event  (fifo_nf_ev[m])
      );

      assign events[2*m]   = fifo_push_ok[m];
      assign events[2*m+1] = fifo_nf_ev[m];
   end

   // ---------------- per-user event registers ----------------
   for (genvar u = 0; u < NUM_USERS; u++) begin : g_user
      logic ack_we, set_we, clr_we;
      assign ack_we = wr_en && (wr_addr == ADDR_W'(user_reg(u, USR_STATUS)));
      assign set_we = wr_en && (wr_addr == ADDR_W'(user_reg(u, USR_EN_SET)));
      assign clr_we = wr_en && (wr_addr == ADDR_W'(user_reg(u, USR_EN_CLR)));

      ipc_mbox_user_irq #(
         .EV_W (EV_W)
      ) u_irq (
         .clk    (clk),
         .rst_n  (rst_n),
         .events (events),
         .ack_we (ack_we),
         .set_we (set_we),
         .clr_we (clr_we),
         .wdata  (wr_data[EV_W-1:0]),
         .status (usr_stat[u]),
         .enable (usr_en[u]),
         .irq    (irq_o[u])
      );
   end

   // ---------------- read path ----------------
   always_comb begin
      rd_val = '0;
      if (rd_addr == ADDR_W'(OFS_REVISION)) rd_val = DATA_W'(REVISION);
      for (int m = 0; m < NUM_FIFOS; m++) begin
         if (rd_addr == ADDR_W'(queue_reg(OFS_MESSAGE, m)))  rd_val = fifo_head[m];
         if (rd_addr == ADDR_W'(queue_reg(OFS_FULLFLAG, m))) rd_val = DATA_W'(fifo_full[m]);
         if (rd_addr == ADDR_W'(queue_reg(OFS_LEVEL, m)))    rd_val = DATA_W'(fifo_lvl[m]);
      end
      for (int u = 0; u < NUM_USERS; u++) begin
         if (rd_addr == ADDR_W'(user_reg(u, USR_STATUS))) rd_val = DATA_W'(usr_stat[u]);
         if (rd_addr == ADDR_W'(user_reg(u, USR_EN_SET)) ||
             rd_addr == ADDR_W'(user_reg(u, USR_EN_CLR)))  rd_val = DATA_W'(usr_en[u]);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) rd_data <= '0;
      else        rd_data <= rd_en ? rd_val : '0;
   end

endmodule

// File: rtl/ipc_mailbox_chk.sv
module ipc_mailbox_chk #(
   parameter int NUM_FIFOS = 4,
   parameter int NUM_USERS = 4,
   parameter int DEPTH     = 4,
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 12,
   localparam int EV_W     = 2 * NUM_FIFOS,
   localparam int LVL_W    = $clog2(DEPTH + 1)
) (
   input logic                            clk,
   input logic                            rst_n,
   input logic                            wr_en,
   input logic [ADDR_W-1:0]               wr_addr,
   input logic [EV_W-1:0]                 wr_ev,
   input logic                            rd_en,
   input logic [ADDR_W-1:0]               rd_addr,
   input logic [DATA_W-1:0]               rd_data,
   input logic [NUM_USERS-1:0]            irq_o,
   input logic [NUM_FIFOS-1:0][LVL_W-1:0] lvl,
   input logic [NUM_USERS-1:0][EV_W-1:0]  stat,
   input logic [NUM_USERS-1:0][EV_W-1:0]  en
);
   import ipc_mbox_pkg::*;

   for (genvar m = 0; m < NUM_FIFOS; m++) begin : g_q
      logic wr_hit, rd_hit;
      assign wr_hit = wr_en && (wr_addr == ADDR_W'(queue_reg(OFS_MESSAGE, m)));
      assign rd_hit = rd_en && (rd_addr == ADDR_W'(queue_reg(OFS_MESSAGE, m)));

      p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
         lvl[m] <= LVL_W'(DEPTH));

      p_full_push_dropped_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_hit && !rd_hit && lvl[m] == LVL_W'(DEPTH)) |=> (lvl[m] == LVL_W'(DEPTH)));

      p_empty_pop_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (rd_hit && !wr_hit && lvl[m] == '0) |=> (rd_data == '0 && lvl[m] == '0));

      for (genvar u = 0; u < NUM_USERS; u++) begin : g_u
         p_new_msg_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_hit && lvl[m] != LVL_W'(DEPTH)) |=> stat[u][2*m]);

         p_not_full_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_hit && lvl[m] == LVL_W'(DEPTH)) |=> stat[u][2*m+1]);
      end
   end

   for (genvar u = 0; u < NUM_USERS; u++) begin : g_usr
      p_enable_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && wr_addr == ADDR_W'(user_reg(u, USR_EN_SET)))
         |=> ((en[u] & $past(wr_ev)) == $past(wr_ev)));

      p_enable_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && wr_addr == ADDR_W'(user_reg(u, USR_EN_CLR)))
         |=> ((en[u] & $past(wr_ev)) == '0));

      p_quiet_when_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
         (en[u] == '0) |-> !irq_o[u]);
   end

endmodule

bind ipc_mailbox ipc_mailbox_chk #(
   .NUM_FIFOS (NUM_FIFOS),
   .NUM_USERS (NUM_USERS),
   .DEPTH     (DEPTH),
   .DATA_W    (DATA_W),
   .ADDR_W    (ADDR_W)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_en   (wr_en),
   .wr_addr (wr_addr),
   .wr_ev   (wr_data[2*NUM_FIFOS-1:0]),
   .rd_en   (rd_en),
   .rd_addr (rd_addr),
   .rd_data (rd_data),
   .irq_o   (irq_o),
   .lvl     (fifo_lvl),
   .stat    (usr_stat),
   .en      (usr_en)
);

// File: tb/ipc_mailbox_bench.sv
`timescale 1ns/1ps
module ipc_mailbox_bench;

   localparam int          NF  = 4;
   localparam int          NU  = 4;
   localparam int          D   = 4;
   localparam int          EVW = 2 * NF;
   localparam logic [31:0] REV = 32'h0001_0200;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [11:0]   wr_addr = '0;
   logic [31:0]   wr_data = '0;
   logic          rd_en = 1'b0;
   logic [11:0]   rd_addr = '0;
   logic [31:0]   rd_data;
   logic [NU-1:0] irq_o;

   ipc_mailbox #(
      .NUM_FIFOS (NF),
      .NUM_USERS (NU),
      .DEPTH     (D),
      .DATA_W    (32),
      .ADDR_W    (12),
      .REVISION  (REV)
   ) u_ipc_mailbox (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_en   (rd_en),
      .rd_addr (rd_addr),
      .rd_data (rd_data),
      .irq_o   (irq_o)
   );

   always #4 clk = ~clk;   // 125 MHz

   // ---------------- reference model ----------------
   logic [31:0]    m_q   [NF][D];
   int             m_cnt [NF];
   logic [EVW-1:0] m_stat[NU];
   logic [EVW-1:0] m_en  [NU];

   int vecs = 0;
   int errs = 0;

   function automatic logic [11:0] a_msg(int m);  return 12'h040 + 12'(4*m);  endfunction
   function automatic logic [11:0] a_full(int m); return 12'h080 + 12'(4*m);  endfunction
   function automatic logic [11:0] a_lvl(int m);  return 12'h0C0 + 12'(4*m);  endfunction
   function automatic logic [11:0] a_stat(int u); return 12'h104 + 12'(16*u); endfunction
   function automatic logic [11:0] a_set(int u);  return 12'h108 + 12'(16*u); endfunction
   function automatic logic [11:0] a_clr(int u);  return 12'h10C + 12'(16*u); endfunction

   function automatic logic [31:0] exp_read(logic [11:0] a);
      logic [31:0] v = '0;
      if (a == 12'h000) v = REV;
      for (int m = 0; m < NF; m++) begin
         if (a == a_msg(m))  v = (m_cnt[m] > 0) ? m_q[m][0] : 32'h0;
         if (a == a_full(m)) v = (m_cnt[m] == D) ? 32'h1 : 32'h0;
         if (a == a_lvl(m))  v = 32'(m_cnt[m]);
      end
      for (int u = 0; u < NU; u++) begin
         if (a == a_stat(u)) v = 32'(m_stat[u]);
         if (a == a_set(u) || a == a_clr(u)) v = 32'(m_en[u]);
      end
      return v;
   endfunction

   function automatic string req_of(logic [11:0] a);
      string r = "R10";
      if (a == 12'h000) r = "R2";
      for (int m = 0; m < NF; m++) begin
         if (a == a_msg(m)) r = "R4";
         if (a == a_full(m) || a == a_lvl(m)) r = "R5";
      end
      for (int u = 0; u < NU; u++) begin
         if (a == a_stat(u)) r = "R7";
         if (a == a_set(u) || a == a_clr(u)) r = "R8";
      end
      return r;
   endfunction

   task automatic model_reset();
      for (int m = 0; m < NF; m++) begin
         m_cnt[m] = 0;
         for (int k = 0; k < D; k++) m_q[m][k] = '0;
      end
      for (int u = 0; u < NU; u++) begin
         m_stat[u] = '0;
         m_en[u]   = '0;
      end
   endtask

   task automatic model_apply(logic we, logic [11:0] wa, logic [31:0] wd,
                              logic re, logic [11:0] ra);
      logic [EVW-1:0] ev = '0;
      bit push [NF];
      bit pop  [NF];
      for (int m = 0; m < NF; m++) begin
         push[m] = we && wa == a_msg(m) && m_cnt[m] < D;
         pop[m]  = re && ra == a_msg(m) && m_cnt[m] > 0;
         if (push[m]) ev[2*m] = 1'b1;
         if (pop[m] && m_cnt[m] == D) ev[2*m+1] = 1'b1;
      end
      for (int u = 0; u < NU; u++) begin
         logic [EVW-1:0] ack;
         ack = (we && wa == a_stat(u)) ? wd[EVW-1:0] : '0;
         m_stat[u] = (m_stat[u] & ~ack) | ev;
         if (we && wa == a_set(u)) m_en[u] = m_en[u] | wd[EVW-1:0];
         if (we && wa == a_clr(u)) m_en[u] = m_en[u] & ~wd[EVW-1:0];
      end
      for (int m = 0; m < NF; m++) begin
         if (pop[m]) begin
            for (int k = 0; k < D - 1; k++) m_q[m][k] = m_q[m][k+1];
            m_cnt[m]--;
         end
         if (push[m]) begin
            m_q[m][m_cnt[m]] = wd;
            m_cnt[m]++;
         end
      end
   endtask

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp, string what);
      vecs++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // One bus cycle: optional write and optional read, then compare ports.
   task automatic step(logic we, logic [11:0] wa, logic [31:0] wd,
                       logic re, logic [11:0] ra, string tag);
      logic [31:0] exp;
      string       rq;
      @(negedge clk);
      wr_en = we; wr_addr = wa; wr_data = wd;
      rd_en = re; rd_addr = ra;
      exp = re ? exp_read(ra) : 32'h0;
      rq  = (tag != "") ? tag : (re ? req_of(ra) : "R2");
      @(posedge clk);
      #2;
      wr_en = 1'b0; rd_en = 1'b0;
      model_apply(we, wa, wd, re, ra);
      chk(rq, rd_data, exp, "rd_data");
      for (int u = 0; u < NU; u++)
         chk((tag != "") ? tag : "R9", 32'(irq_o[u]),
             32'(|(m_stat[u] & m_en[u])), "irq_o");
   endtask

   task automatic wr(logic [11:0] a, logic [31:0] d, string tag);
      step(1'b1, a, d, 1'b0, 12'h0, tag);
   endtask

   task automatic rd(logic [11:0] a, string tag);
      step(1'b0, 12'h0, 32'h0, 1'b1, a, tag);
   endtask

   task automatic sweep(string tag);
      rd(12'h000, tag);
      for (int m = 0; m < NF; m++) begin
         rd(a_full(m), tag);
         rd(a_lvl(m), tag);
      end
      for (int u = 0; u < NU; u++) begin
         rd(a_stat(u), tag);
         rd(a_set(u), tag);
      end
   endtask

   function automatic logic [11:0] rand_addr();
      int k = int'($urandom % 10);
      int i = int'($urandom % 4);
      case (k)
         0, 1, 2, 3: return a_msg(i);
         4:          return a_full(i);
         5:          return a_lvl(i);
         6:          return a_stat(i);
         7:          return a_set(i);
         8:          return a_clr(i);
         default: begin
            case (i)
               0: return 12'h000;
               1: return 12'h010;
               2: return 12'h100;
               default: return 12'h1F4;
            endcase
         end
      endcase
   endfunction

   // watchdog
   initial begin
      #(8 * 150000);
      errs++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
   end

   initial begin
      int seed;
      seed = 20240611;
      void'($urandom(seed));
      model_reset();
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: everything clear after reset
      #1;
      for (int u = 0; u < NU; u++) chk("R1", 32'(irq_o[u]), 32'h0, "irq after reset");
      chk("R1", rd_data, 32'h0, "rd_data after reset");
      sweep("R1");

      // R2: revision read, write to it ignored, idle cycle reads 0
      rd(12'h000, "R2");
      wr(12'h000, 32'hDEAD_BEEF, "R2");
      rd(12'h000, "R2");
      step(1'b0, 12'h0, 32'h0, 1'b0, 12'h0, "R2");

      // R10: unmapped and read-only writes change nothing
      wr(12'h010, 32'hFFFF_FFFF, "R10");
      wr(12'h100, 32'hFFFF_FFFF, "R10");
      wr(a_full(0), 32'hFFFF_FFFF, "R10");
      wr(a_lvl(1), 32'h3, "R10");
      rd(12'h010, "R10");
      rd(12'h1F4, "R10");
      sweep("R10");

      // R8 / R9: enable all events for user 0
      wr(a_set(0), 32'hFF, "R8");
      rd(a_clr(0), "R8");

      // R3: fill queue 1, overflow push discarded
      for (int k = 0; k < D; k++) wr(a_msg(1), 32'h1000 + 32'(k), "R3");
      wr(a_msg(1), 32'hBAD0_0001, "R3");
      rd(a_lvl(1), "R5");
      rd(a_full(1), "R5");

      // R4: drain in order, then pop empty
      for (int k = 0; k < D; k++) rd(a_msg(1), "R4");
      rd(a_msg(1), "R4");
      rd(a_lvl(1), "R4");
      rd(a_stat(2), "R6");

      // R7: ack write of 0 has no effect; write 1 clears
      wr(a_stat(0), 32'h0, "R7");
      rd(a_stat(0), "R7");
      wr(a_stat(0), 32'h04, "R7");
      rd(a_stat(0), "R7");

      // R7: event beats a simultaneous clear (not-full bit of queue 2)
      for (int k = 0; k < D; k++) wr(a_msg(2), 32'h2000 + 32'(k), "R3");
      wr(a_stat(1), 32'hFF, "R7");
      step(1'b1, a_stat(1), 32'hFF, 1'b1, a_msg(2), "R7");
      rd(a_stat(1), "R7");

      // R4: push and pop of the same queue in one cycle
      step(1'b1, a_msg(3), 32'h3333, 1'b1, a_msg(3), "R4");
      step(1'b1, a_msg(3), 32'h4444, 1'b1, a_msg(3), "R4");
      rd(a_lvl(3), "R4");

      // R11: user 2 acknowledgement and enable leave user 3 intact
      wr(a_set(3), 32'h0F, "R11");
      wr(a_stat(2), 32'hFF, "R11");
      wr(a_set(2), 32'hF0, "R11");
      wr(a_clr(2), 32'hFF, "R11");
      rd(a_stat(3), "R11");
      rd(a_set(3), "R11");
      sweep("R11");

      // R8: clear enables of user 0, interrupt must drop
      wr(a_clr(0), 32'hFF, "R9");
      rd(a_set(0), "R8");

      // constrained random traffic
      for (int i = 0; i < 4000; i++) begin
         logic        we, re;
         logic [11:0] wa, ra;
         logic [31:0] wd;
         we = ($urandom % 10) < 7;
         re = ($urandom % 10) < 7;
         wa = rand_addr();
         ra = rand_addr();
         wd = ($urandom % 3 == 0) ? 32'($urandom % 256) : $urandom;
         step(we, wa, wd, re, ra, "");
      end
      sweep("R5");

      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
   end

endmodule